// File: doc/BRIEF.md
# Synthesizer Reference and Feedback Divider Core

This block holds the digital part of an integer-N frequency synthesizer. It has two counters and a phase/frequency detector. One counter divides the reference clock by a small set of fixed ratios. The other divides the oscillator feedback clock by a programmable 9-bit ratio. Each counter emits a one-cycle terminal pulse. The detector compares the two pulse streams and drives UP/DOWN requests toward an external charge pump. A 3-bit pump current code is held in a register and presented on an output.

The core runs on one fabric clock. The reference and feedback clock edges arrive as one-cycle strobes (`ref_tick`, `fb_tick`) from edge detectors outside the block. Settings are written with a load strobe. A write is accepted whether or not the synthesizer is powered. While `pwr_on` is low, both counters and the detector are held idle and the stored settings are kept. When power returns, the block waits for a reference strobe to align both counters before counting starts.

Top module: `synth_divider_core`

## Requirements
- R1: During and after reset, the stored feedback ratio is 400, the reference code is 00 and the pump current code reads 111. `ref_pulse`, `fb_pulse`, `pd_up` and `pd_dn` are low.
- R2: While running, `fb_pulse` is high for one cycle on every N-th accepted `fb_tick`. It rises in the cycle after the edge at which that strobe is sampled. N is the stored 9-bit ratio.
- R3: While running, `ref_pulse` marks every R-th accepted `ref_tick` with the same timing. R is 13 for code 0, 26 for code 1, 39 for code 2 and 52 for code 3.
- R4: A loaded N below 64 is stored as 64. Values from 64 to 511 are stored unchanged.
- R5: A newly loaded ratio or code governs a divider only from that divider's next terminal pulse onward. The period in progress finishes with the old ratio.
- R6: `cp_code` shows the value of `cp_in` from the cycle after a `cfg_load` and holds it until the next load. Code 000 is least current and 111 is most current.
- R7: A reference pulse sets `pd_up` and a feedback pulse sets `pd_dn`, one cycle later. When both would be set, both clear. `pd_up` and `pd_dn` are never high together.
- R8: While `pwr_on` is low, both counters are held at zero. No terminal pulse is produced and `pd_up`/`pd_dn` are forced low from the next cycle.
- R9: Settings loaded while powered down are stored. The settings held at power-down are used after power returns.
- R10: After `pwr_on` rises, both counters stay idle until the first `ref_tick`. That strobe only arms the counters and is not counted. Both counters then count from zero.
- R11: Each terminal pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Synthesizer power-on, active high |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| fb_tick | input | 1 | One-cycle strobe per oscillator feedback edge |
| cfg_load | input | 1 | Store n_in, ref_code_in and cp_in |
| n_in | input | 9 | Feedback division ratio |
| ref_code_in | input | 2 | Reference ratio select |
| cp_in | input | 3 | Charge-pump current code |
| ref_pulse | output | 1 | Reference terminal pulse |
| fb_pulse | output | 1 | Feedback terminal pulse |
| pd_up | output | 1 | Detector UP request |
| pd_dn | output | 1 | Detector DOWN request |
| cp_code | output | 3 | Registered pump current code |

## Verification
The terminal pulses and `cp_code` are due one clock edge after the strobe or load that causes them. `pd_up`/`pd_dn` are due one edge after the pulse they respond to, two edges after the tick.

The bench drives every input just after a falling edge. It advances its own cycle model at the rising edge and compares all outputs at the next falling edge. Each expectation is therefore checked in exactly the cycle it is due.

Directed runs count strobes between successive pulses to confirm the clamped feedback ratio and the largest reference ratio.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int N_W      = 9;
  localparam int N_MIN    = 64;
  localparam int N_RST    = 400;
  localparam int RC_W     = 2;
  localparam int CP_W     = 3;
  localparam int REF_BASE = 13;
endpackage

// File: rtl/sd_settings.sv
module sd_settings #(
  parameter int N_W   = 9,
  parameter int RC_W  = 2,
  parameter int CP_W  = 3,
  parameter int N_MIN = 64,
  parameter int N_RST = 400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [N_W-1:0]  n_in,
  input  logic [RC_W-1:0] rc_in,
  input  logic [CP_W-1:0] cp_in,
  output logic [N_W-1:0]  n_q,
  output logic [RC_W-1:0] rc_q,
  output logic [CP_W-1:0] cp_q
);
  localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);
  localparam logic [N_W-1:0] N_INIT  = N_W'(N_RST);

  logic [N_W-1:0] n_clamped;

  always_comb begin
    n_clamped = (n_in < N_FLOOR) ? N_FLOOR : n_in;
  end

  // Stored values survive power-down; only reset or a load changes them.
  always_ff @(posedge clk) begin
    if (rst) begin
      n_q  <= N_INIT;
      rc_q <= '0;
      cp_q <= '1;
    end else if (load) begin
      n_q  <= n_clamped;
      rc_q <= rc_in;
      cp_q <= cp_in;
    end
  end
endmodule

// File: rtl/sd_divider.sv
module sd_divider #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] active;
  logic         at_end;

  always_comb begin
    at_end = (cnt == active - W'(1));
  end

  // The ratio is captured only while idle or at a terminal count, so a
  // change never shortens the period in progress.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      active <= ratio;
      pulse  <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (at_end) begin
          cnt    <= '0;
          active <= ratio;
          pulse  <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sd_pfd.sv
module sd_pfd (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ref_hit,
  input  logic fb_hit,
  output logic up,
  output logic dn
);
  logic up_nx, dn_nx;

  always_comb begin
    up_nx = up | ref_hit;
    dn_nx = dn | fb_hit;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx;
      dn <= dn_nx;
    end
  end
endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
  import sd_pkg::*;
#(
  parameter int NW       = N_W,
  parameter int RCW      = RC_W,
  parameter int CPW      = CP_W,
  parameter int NMIN     = N_MIN,
  parameter int NRST     = N_RST,
  parameter int REFBASE  = REF_BASE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_on,
  input  logic           ref_tick,
  input  logic           fb_tick,
  input  logic           cfg_load,
  input  logic [NW-1:0]  n_in,
  input  logic [RCW-1:0] ref_code_in,
  input  logic [CPW-1:0] cp_in,
  output logic           ref_pulse,
  output logic           fb_pulse,
  output logic           pd_up,
  output logic           pd_dn,
  output logic [CPW-1:0] cp_code
);
  localparam int REF_MAX = REFBASE * (2 ** RCW);
  localparam int RW      = $clog2(REF_MAX + 1);

  logic [NW-1:0]  n_q;
  logic [RCW-1:0] rc_q;
  logic [RW-1:0]  ref_ratio;
  logic           armed;
  logic           run;

  sd_settings #(
    .N_W(NW), .RC_W(RCW), .CP_W(CPW), .N_MIN(NMIN), .N_RST(NRST)
  ) u_settings (
    .clk(clk), .rst(rst), .load(cfg_load),
    .n_in(n_in), .rc_in(ref_code_in), .cp_in(cp_in),
    .n_q(n_q), .rc_q(rc_q), .cp_q(cp_code)
  );

  always_comb begin
    ref_ratio = RW'(REFBASE * (int'(rc_q) + 1));
  end

  // Arm on the first reference strobe after power-up; that strobe is not counted.
  always_ff @(posedge clk) begin
    if (rst || !pwr_on) armed <= 1'b0;
    else if (ref_tick)  armed <= 1'b1;
  end

  always_comb begin
    run = armed && pwr_on;
  end

  sd_divider #(.W(RW)) u_ref_div (
    .clk(clk), .rst(rst), .run(run), .tick(ref_tick),
    .ratio(ref_ratio), .pulse(ref_pulse)
  );

  sd_divider #(.W(NW)) u_fb_div (
    .clk(clk), .rst(rst), .run(run), .tick(fb_tick),
    .ratio(n_q), .pulse(fb_pulse)
  );

  sd_pfd u_pfd (
    .clk(clk), .rst(rst), .enable(pwr_on),
    .ref_hit(ref_pulse), .fb_hit(fb_pulse),
    .up(pd_up), .dn(pd_dn)
  );
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int CPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           pwr_on,
  input logic           cfg_load,
  input logic [CPW-1:0] cp_in,
  input logic           ref_pulse,
  input logic           fb_pulse,
  input logic           pd_up,
  input logic           pd_dn,
  input logic [CPW-1:0] cp_code
);
  AST_PFD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pd_up && pd_dn)); // R7

  AST_UP_ON_REF: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && !fb_pulse && !pd_dn && pwr_on) |=> pd_up); // R7

  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (!ref_pulse && !fb_pulse && !pd_up && !pd_dn)); // R8

  AST_CP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (cp_code == $past(cp_in))); // R6

  AST_CP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cp_code)); // R6

  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse); // R11

  AST_FB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R11
endmodule

bind synth_divider_core sd_checker #(.CPW(CPW)) u_sd_checker (
  .clk(clk), .rst(rst), .pwr_on(pwr_on), .cfg_load(cfg_load), .cp_in(cp_in),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .pd_up(pd_up), .pd_dn(pd_dn),
  .cp_code(cp_code)
);

// File: tb/synth_divider_core_tb_top.sv
`timescale 1ns/1ps
module synth_divider_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_on = 1'b0, ref_tick = 1'b0, fb_tick = 1'b0, cfg_load = 1'b0;
  logic [8:0] n_in = '0;
  logic [1:0] ref_code_in = '0;
  logic [2:0] cp_in = '0;
  logic       ref_pulse, fb_pulse, pd_up, pd_dn;
  logic [2:0] cp_code;

  int checks = 0, errors = 0;

  always #10 clk = ~clk; // 50 MHz

  synth_divider_core dut_i (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .cfg_load(cfg_load), .n_in(n_in), .ref_code_in(ref_code_in), .cp_in(cp_in),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .pd_up(pd_up), .pd_dn(pd_dn),
    .cp_code(cp_code)
  );

  // Bench-side reference model state
  int m_n, m_rc, m_cp, m_rcnt, m_ract, m_fcnt, m_fact;
  bit m_arm, m_rp, m_fp, m_up, m_dn;

  function automatic int ref_div(input int code);
    return 13 * (code + 1);
  endfunction

  function automatic int clamp_n(input int n);
    return (n < 64) ? 64 : n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_n = 400; m_rc = 0; m_cp = 7;
    m_rcnt = 0; m_fcnt = 0; m_ract = ref_div(0); m_fact = 400;
    m_arm = 0; m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
  endtask

  task automatic model_edge();
    bit run, u, d, nrp, nfp;
    run = m_arm && pwr_on;
    // detector from old pulses
    if (!pwr_on) begin u = 0; d = 0; end
    else begin
      u = m_up | m_rp; d = m_dn | m_fp;
      if (u && d) begin u = 0; d = 0; end
    end
    // reference divider
    nrp = 0;
    if (!run) begin m_rcnt = 0; m_ract = ref_div(m_rc); end
    else if (ref_tick) begin
      if (m_rcnt == m_ract - 1) begin m_rcnt = 0; nrp = 1; m_ract = ref_div(m_rc); end
      else m_rcnt++;
    end
    // feedback divider
    nfp = 0;
    if (!run) begin m_fcnt = 0; m_fact = m_n; end
    else if (fb_tick) begin
      if (m_fcnt == m_fact - 1) begin m_fcnt = 0; nfp = 1; m_fact = m_n; end
      else m_fcnt++;
    end
    if (!pwr_on) m_arm = 0; else if (ref_tick) m_arm = 1;
    if (cfg_load) begin m_n = clamp_n(int'(n_in)); m_rc = int'(ref_code_in); m_cp = int'(cp_in); end
    m_up = u; m_dn = d; m_rp = nrp; m_fp = nfp;
  endtask

  task automatic compare_all();
    chk("R3 ref_pulse", int'(ref_pulse), int'(m_rp));
    chk("R2 fb_pulse",  int'(fb_pulse),  int'(m_fp));
    chk("R7 pd_up",     int'(pd_up),     int'(m_up));
    chk("R7 pd_dn",     int'(pd_dn),     int'(m_dn));
    chk("R6 cp_code",   int'(cp_code),   m_cp);
  endtask

  // Called just after a falling edge; advances one cycle and compares.
  task automatic step(input bit p, input bit rt, input bit ft, input bit ld,
                      input int n, input int rc, input int cp);
    pwr_on = p; ref_tick = rt; fb_tick = ft; cfg_load = ld;
    n_in = 9'(n); ref_code_in = 2'(rc); cp_in = 3'(cp);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  // Count strobes between two successive pulses with ticks every cycle.
  task automatic measure(input bit use_ref, input string req, input int exp);
    int seen, cnt, gap;
    seen = 0; cnt = 0; gap = 0;
    for (int i = 0; i < 400 && seen < 2; i++) begin
      step(1, 1, 1, 0, 0, 0, 0);
      if (seen == 1) cnt++;
      if (use_ref ? ref_pulse : fb_pulse) begin
        if (seen == 1) gap = cnt;
        seen++; cnt = 0;
      end
    end
    chk(req, gap, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    int dn_left;
    bit p;
    seed = 17;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 cp_code reset", int'(cp_code), 7);
    chk("R1 outputs low", int'({ref_pulse, fb_pulse, pd_up, pd_dn}), 0);
    rst = 1'b0;

    // R10: powered but no ref strobe -> nothing counts despite fb strobes
    for (int i = 0; i < 500; i++) step(1, 0, 1, 0, 0, 0, 0);
    chk("R10 idle before arming", int'(fb_pulse), 0);

    // R4 + R9: load N=10 (clamped) and code 3 while powered down
    step(0, 0, 0, 1, 10, 3, 2);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0); // arming strobe
    measure(0, "R4 clamped feedback period", 64);
    measure(1, "R3 ratio 52 period", 52);

    // R5: change N mid-period; model tracks old/new ratio timing
    step(1, 0, 1, 1, 100, 1, 5);
    for (int i = 0; i < 300; i++) step(1, 1, 1, 0, 0, 0, 0);

    // Constrained random phase with occasional power drops and reloads
    dn_left = 0;
    for (int i = 0; i < 30000; i++) begin
      bit ld;
      if (dn_left > 0) dn_left--;
      else if ($urandom_range(0, 2999) == 0) dn_left = $urandom_range(2, 40);
      p  = (dn_left == 0);
      ld = ($urandom_range(0, 399) == 0);
      step(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ld,
           ($urandom_range(0, 4) == 0) ? $urandom_range(0, 63) : $urandom_range(64, 511),
           $urandom_range(0, 3), $urandom_range(0, 7));
      if (!p) chk("R8 quiet while down", int'({ref_pulse, fb_pulse, pd_up, pd_dn}), 0);
    end

    // R11: pulse lasts one cycle at the fastest ratio
    step(1, 0, 0, 1, 64, 0, 0);
    for (int i = 0; i < 200; i++) begin
      step(1, 1, 1, 0, 0, 0, 0);
      if (ref_pulse) begin
        step(1, 1, 1, 0, 0, 0, 0);
        chk("R11 ref pulse width", int'(ref_pulse), 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule